// File: doc/BRIEF.md
# Address-Latched BCD Clock Register File

This block gives a host a byte-wide window of four port offsets into a 16-bit address space. The host loads the low and high address bytes through two of the offsets and then moves one data byte through a third. Below the clock page, addresses that fall inside the configured memory size reach a byte store. The sixteen addresses 0x1FF0 to 0x1FFF form a page of clock registers. Addresses outside both regions read as 0xFF.

The clock page holds a running time of day in BCD, from seconds up to the year. It also holds a stop bit, a weekday with a century bit, and a control byte. A one-second tick input advances the time. Writes to time fields are taken only when the value is a valid BCD number inside the field's range. The alarm bytes, the interrupt byte and the watchdog byte are held here and driven out to neighbouring blocks. A watchdog restart pulse goes out with them. The date wraps after day 31 in every month.

Top module: `rtc_regfile_top`

## Requirements
- R1: A write to offset 0 replaces the low byte of the latched address, and a write to offset 1 replaces the high byte. A read pulse on `bus_rd` loads `bus_rdata` at that clock edge. A read at any offset other than 3 returns 0xFF. `bus_rdata` resets to 0xFF.
- R2: A write to offset 3 stores the data byte at the latched address. On the same edge the latched address returns to 0x0000.
- R3: An address below MEM_BYTES and outside 0x1FF0–0x1FFF reads back the last byte written to it. Any other address outside the clock page reads 0xFF and ignores writes. Address 0x1FF1 does the same.
- R4: Address 0x1FF0 reads the `flags_in` input and ignores writes. A read of 0x1FF0, or a write of 0x1FF7, raises `wdog_restart_o` for one cycle, starting on the next cycle. A write of 0x1FF7 also updates `wdog_cfg_o`.
- R5: A write to the control byte at 0x1FF8 stores (value AND 0x5F) OR 0x90, so bits 7 and 4 end up set and bit 5 ends up clear.
- R6: Each write to a time field is masked and range-checked before it is stored: seconds at 0x1FF9 (bits 6:0) and minutes at 0x1FFA (bits 6:0) accept 0–59, hours at 0x1FFB (bits 5:0) accept 0–23, the date at 0x1FFD (bits 5:0) accepts 1–31, the month at 0x1FFE (bits 4:0) accepts 1–12, and the year at 0x1FFF (all 8 bits) accepts 0–99. A value with a nibble above 9, or outside its range, leaves the field unchanged.
- R7: Bit 7 of 0x1FF9 is the stop bit, and it is written on every seconds write, whether or not the seconds digits are accepted. While it is set, ticks have no effect. When it clears, counting resumes from the held time. A seconds read returns the stop bit in bit 7 and the BCD seconds in bits 6:0.
- R8: At 0x1FFC, bits 2:0 hold the weekday and bit 6 holds the century bit. Reads return both fields with all other bits zero.
- R9: With the stop bit clear, a `sec_tick` pulse advances the seconds. The carry then passes on at each wrap: 59 s carries to minutes, 59 min to hours, 23 h to the date and the weekday, date 31 to the month, month 12 to the year, and year 99 to 00, which toggles the century bit. The weekday counts from 7 back to 1.
- R10: A tick in the same cycle as a write to any register from 0x1FF9 to 0x1FFF is dropped. The write takes effect as normal.
- R11: The alarm bytes at 0x1FF2–0x1FF5 and the interrupt byte at 0x1FF6 store any written value unchanged and read it back. They drive `alarm_sec_o`, `alarm_min_o`, `alarm_hour_o`, `alarm_date_o` and `irq_cfg_o`.
- R12: After reset the time reads 00:00:00, the weekday reads 1 with the century bit clear, the date and month read 01, and the year reads 00. The stop bit, the control byte and all alarm, interrupt and watchdog bytes reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the port selected by bus_ofs |
| bus_rd | input | 1 | Read strobe for the port selected by bus_ofs |
| bus_ofs | input | 2 | Port offset: 0 low address, 1 high address, 3 data |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data, registered |
| sec_tick | input | 1 | One-cycle pulse once per second |
| flags_in | input | 8 | Flag byte from neighbouring logic, read at 0x1FF0 |
| alarm_sec_o | output | 8 | Stored alarm seconds byte |
| alarm_min_o | output | 8 | Stored alarm minutes byte |
| alarm_hour_o | output | 8 | Stored alarm hours byte |
| alarm_date_o | output | 8 | Stored alarm date byte |
| irq_cfg_o | output | 8 | Stored interrupt byte |
| wdog_cfg_o | output | 8 | Stored watchdog byte |
| wdog_restart_o | output | 1 | One-cycle watchdog restart pulse |

## Verification
The assertions assume a well-behaved host: `bus_wr` and `bus_rd` are never high in the same cycle, and `sec_tick` is a single-cycle pulse. The range and carry properties also depend on every time field coming out of reset or a checked write in a legal state. The bench keeps to these rules by issuing exactly one strobe per bus task and driving each tick in its own cycle. The one exception is the R10 test, which raises a tick together with a clock-page write on purpose.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int BUS_AW = 16;
  localparam logic [11:0] CLK_PAGE = 12'h1FF;

  typedef enum logic [3:0] {
    RG_FLAGS = 4'h0, RG_RSV  = 4'h1, RG_ASEC = 4'h2, RG_AMIN  = 4'h3,
    RG_AHOUR = 4'h4, RG_ADATE = 4'h5, RG_IRQ = 4'h6, RG_WDOG  = 4'h7,
    RG_CTRL  = 4'h8, RG_SEC  = 4'h9, RG_MIN  = 4'hA, RG_HOUR  = 4'hB,
    RG_DAY   = 4'hC, RG_DATE = 4'hD, RG_MON  = 4'hE, RG_YEAR  = 4'hF
  } rtc_reg_e;

  function automatic logic bcd_ok(input logic [7:0] b);
    return (b[3:0] <= 4'd9) && (b[7:4] <= 4'd9);
  endfunction

  function automatic logic [6:0] bcd_bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic bcd_in_range(input logic [7:0] b,
                                        input logic [6:0] lo,
                                        input logic [6:0] hi);
    return bcd_ok(b) && (bcd_bin(b) >= lo) && (bcd_bin(b) <= hi);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    if (b[3:0] >= 4'd9) return {b[7:4] + 4'd1, 4'd0};
    return {b[7:4], b[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] ctrl_fmt(input logic [7:0] v);
    return (v & 8'h5F) | 8'h90;
  endfunction

endpackage

// File: rtl/rtc_addr_latch.sv
module rtc_addr_latch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          clr,
  input  logic [7:0]    din,
  output logic [AW-1:0] addr
);
  localparam int HI_W = AW - 8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (clr) begin
      addr <= '0;
    end else begin
      if (ld_lo) addr[7:0]    <= din;
      if (ld_hi) addr[AW-1:8] <= din[HI_W-1:0];
    end
  end
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  rtc_reg_e   wr_idx,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic [2:0] wday_q,
  output logic       cent_q,
  output logic [7:0] date_q,
  output logic [7:0] mon_q,
  output logic [7:0] year_q,
  output logic       stop_q,
  output logic       tick_ev,
  output logic       held_ev
);
  logic c_sec, c_min, c_hour, c_date, c_mon, c_year;
  logic [7:0] w_sec, w_min, w_hour, w_date, w_mon;

  assign tick_ev = tick && !stop_q && !wr_en;
  assign held_ev = tick && stop_q && !wr_en;

  assign c_sec  = (sec_q  == 8'h59);
  assign c_min  = c_sec  && (min_q  == 8'h59);
  assign c_hour = c_min  && (hour_q == 8'h23);
  assign c_date = c_hour && (date_q == 8'h31);
  assign c_mon  = c_date && (mon_q  == 8'h12);
  assign c_year = c_mon  && (year_q == 8'h99);

  assign w_sec  = {1'b0, wr_data[6:0]};
  assign w_min  = {1'b0, wr_data[6:0]};
  assign w_hour = {2'b0, wr_data[5:0]};
  assign w_date = {2'b0, wr_data[5:0]};
  assign w_mon  = {3'b0, wr_data[4:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
      wday_q <= 3'd1;
      cent_q <= 1'b0;
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
      stop_q <= 1'b0;
    end else if (wr_en) begin
      unique case (wr_idx)
        RG_SEC: begin
          stop_q <= wr_data[7];
          if (bcd_in_range(w_sec, 7'd0, 7'd59)) sec_q <= w_sec;
        end
        RG_MIN:  if (bcd_in_range(w_min, 7'd0, 7'd59))  min_q  <= w_min;
        RG_HOUR: if (bcd_in_range(w_hour, 7'd0, 7'd23)) hour_q <= w_hour;
        RG_DAY: begin
          wday_q <= wr_data[2:0];
          cent_q <= wr_data[6];
        end
        RG_DATE: if (bcd_in_range(w_date, 7'd1, 7'd31)) date_q <= w_date;
        RG_MON:  if (bcd_in_range(w_mon, 7'd1, 7'd12))  mon_q  <= w_mon;
        RG_YEAR: if (bcd_in_range(wr_data, 7'd0, 7'd99)) year_q <= wr_data;
        default: ;
      endcase
    end else if (tick_ev) begin
      sec_q <= c_sec ? 8'h00 : bcd_inc(sec_q);
      if (c_sec)  min_q  <= c_min  ? 8'h00 : bcd_inc(min_q);
      if (c_min)  hour_q <= c_hour ? 8'h00 : bcd_inc(hour_q);
      if (c_hour) begin
        wday_q <= (wday_q >= 3'd7) ? 3'd1 : wday_q + 3'd1;
        date_q <= c_date ? 8'h01 : bcd_inc(date_q);
      end
      if (c_date) mon_q  <= c_mon ? 8'h01 : bcd_inc(mon_q);
      if (c_mon)  year_q <= c_year ? 8'h00 : bcd_inc(year_q);
      if (c_year) cent_q <= ~cent_q;
    end
  end
endmodule

// File: rtl/rtc_regfile_top.sv
module rtc_regfile_top
  import rtc_pkg::*;
#(
  parameter int MEM_BYTES = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_ofs,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sec_tick,
  input  logic [7:0] flags_in,
  output logic [7:0] alarm_sec_o,
  output logic [7:0] alarm_min_o,
  output logic [7:0] alarm_hour_o,
  output logic [7:0] alarm_date_o,
  output logic [7:0] irq_cfg_o,
  output logic [7:0] wdog_cfg_o,
  output logic       wdog_restart_o
);
  localparam int MAW = $clog2(MEM_BYTES);
  localparam logic [BUS_AW:0] MEM_LIM = (BUS_AW+1)'(MEM_BYTES);
  localparam int N_CFG = 5;

  logic [BUS_AW-1:0] addr_q;
  logic       data_wr_ev, data_rd_ev, page_hit, mem_hit;
  logic       clk_wr, ctrl_wr_ev;
  rtc_reg_e   ridx;
  logic [7:0] mem_rdata, rd_val, ctrl_q;
  logic [7:0] sec_q, min_q, hour_q, date_q, mon_q, year_q;
  logic [2:0] wday_q;
  logic       cent_q, stop_q, tick_ev, held_ev;
  logic [7:0] cfg_q [N_CFG];

  assign data_wr_ev = bus_wr && (bus_ofs == 2'd3);
  assign data_rd_ev = bus_rd && (bus_ofs == 2'd3);
  assign page_hit   = (addr_q[BUS_AW-1:4] == CLK_PAGE);
  assign mem_hit    = !page_hit && ({1'b0, addr_q} < MEM_LIM);
  assign ridx       = rtc_reg_e'(addr_q[3:0]);
  assign clk_wr     = data_wr_ev && page_hit && (addr_q[3:0] >= 4'h9);
  assign ctrl_wr_ev = data_wr_ev && page_hit && (ridx == RG_CTRL);

  rtc_addr_latch #(.AW(BUS_AW)) u_alat (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_lo (bus_wr && (bus_ofs == 2'd0)),
    .ld_hi (bus_wr && (bus_ofs == 2'd1)),
    .clr   (data_wr_ev),
    .din   (bus_wdata),
    .addr  (addr_q)
  );

  rtc_byte_store #(.DEPTH(MEM_BYTES)) u_store (
    .clk   (clk),
    .we    (data_wr_ev && mem_hit),
    .waddr (addr_q[MAW-1:0]),
    .wdata (bus_wdata),
    .raddr (addr_q[MAW-1:0]),
    .rdata (mem_rdata)
  );

  rtc_time_core u_time (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sec_tick),
    .wr_en   (clk_wr),
    .wr_idx  (ridx),
    .wr_data (bus_wdata),
    .sec_q   (sec_q),
    .min_q   (min_q),
    .hour_q  (hour_q),
    .wday_q  (wday_q),
    .cent_q  (cent_q),
    .date_q  (date_q),
    .mon_q   (mon_q),
    .year_q  (year_q),
    .stop_q  (stop_q),
    .tick_ev (tick_ev),
    .held_ev (held_ev)
  );

  // raw-stored alarm and interrupt bytes at page indices 2..6
  for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n) cfg_q[g] <= 8'h00;
      else if (data_wr_ev && page_hit && (addr_q[3:0] == 4'(g + 2)))
        cfg_q[g] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q         <= 8'h00;
      wdog_cfg_o     <= 8'h00;
      wdog_restart_o <= 1'b0;
    end else begin
      if (ctrl_wr_ev) ctrl_q <= ctrl_fmt(bus_wdata);
      if (data_wr_ev && page_hit && (ridx == RG_WDOG)) wdog_cfg_o <= bus_wdata;
      wdog_restart_o <= page_hit &&
                        ((data_wr_ev && (ridx == RG_WDOG)) ||
                         (data_rd_ev && (ridx == RG_FLAGS)));
    end
  end

  always_comb begin
    rd_val = 8'hFF;
    if (mem_hit) begin
      rd_val = mem_rdata;
    end else if (page_hit) begin
      unique case (ridx)
        RG_FLAGS: rd_val = flags_in;
        RG_RSV:   rd_val = 8'hFF;
        RG_ASEC:  rd_val = cfg_q[0];
        RG_AMIN:  rd_val = cfg_q[1];
        RG_AHOUR: rd_val = cfg_q[2];
        RG_ADATE: rd_val = cfg_q[3];
        RG_IRQ:   rd_val = cfg_q[4];
        RG_WDOG:  rd_val = wdog_cfg_o;
        RG_CTRL:  rd_val = ctrl_q;
        RG_SEC:   rd_val = {stop_q, sec_q[6:0]};
        RG_MIN:   rd_val = min_q;
        RG_HOUR:  rd_val = hour_q;
        RG_DAY:   rd_val = {1'b0, cent_q, 3'b000, wday_q};
        RG_DATE:  rd_val = date_q;
        RG_MON:   rd_val = mon_q;
        RG_YEAR:  rd_val = year_q;
        default:  rd_val = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= 8'hFF;
    else if (bus_rd) bus_rdata <= (bus_ofs == 2'd3) ? rd_val : 8'hFF;
  end

  assign alarm_sec_o  = cfg_q[0];
  assign alarm_min_o  = cfg_q[1];
  assign alarm_hour_o = cfg_q[2];
  assign alarm_date_o = cfg_q[3];
  assign irq_cfg_o    = cfg_q[4];
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        data_wr_ev,
  input logic [15:0] addr_q,
  input logic        ctrl_wr_ev,
  input logic [7:0]  ctrl_q,
  input logic [7:0]  sec_q,
  input logic [7:0]  hour_q,
  input logic [7:0]  mon_q,
  input logic        tick_ev,
  input logic        held_ev
);
  // R2
  addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_ev |=> (addr_q == 16'h0000));

  // R5
  ctrl_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_ev |=> (ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]));

  // R6
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q <= 8'h59) && (sec_q[3:0] <= 4'd9));

  // R6
  hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_q <= 8'h23) && (hour_q[3:0] <= 4'd9));

  // R6
  mon_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_q >= 8'h01) && (mon_q <= 8'h12) && (mon_q[3:0] <= 4'd9));

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_ev |=> $stable(sec_q));

  // R9
  tick_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_ev |=> (sec_q != $past(sec_q)));
endmodule

bind rtc_regfile_top rtc_regfile_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .data_wr_ev (data_wr_ev),
  .addr_q     (addr_q),
  .ctrl_wr_ev (ctrl_wr_ev),
  .ctrl_q     (ctrl_q),
  .sec_q      (sec_q),
  .hour_q     (hour_q),
  .mon_q      (mon_q),
  .tick_ev    (tick_ev),
  .held_ev    (held_ev)
);

// File: tb/sim_rtc_regfile_top.sv
`timescale 1ns/1ps
module sim_rtc_regfile_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, sec_tick = 1'b0;
  logic [1:0] bus_ofs = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] flags_in = 8'h5A;
  logic [7:0] bus_rdata, alarm_sec_o, alarm_min_o, alarm_hour_o, alarm_date_o;
  logic [7:0] irq_cfg_o, wdog_cfg_o;
  logic       wdog_restart_o;

  int n_run = 0, n_fail = 0, n_restart = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_regfile_top #(.MEM_BYTES(2048)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sec_tick(sec_tick), .flags_in(flags_in),
    .alarm_sec_o(alarm_sec_o), .alarm_min_o(alarm_min_o),
    .alarm_hour_o(alarm_hour_o), .alarm_date_o(alarm_date_o),
    .irq_cfg_o(irq_cfg_o), .wdog_cfg_o(wdog_cfg_o),
    .wdog_restart_o(wdog_restart_o)
  );

  always @(negedge clk) if (rst_n && wdog_restart_o) n_restart++;

  // {address, write byte, expected read-back}
  localparam logic [31:0] VEC [22] = '{
    32'h0010_A5_A5, 32'h07FF_3C_3C, 32'h0800_12_FF, 32'h1FF1_55_FF,
    32'h1FF8_2A_9A, 32'h1FF8_FF_DF, 32'h1FFA_45_45, 32'h1FFA_60_45,
    32'h1FFB_23_23, 32'h1FFB_24_23, 32'h1FFE_12_12, 32'h1FFE_00_12,
    32'h1FFE_13_12, 32'h1FFF_99_99, 32'h1FFF_9A_99, 32'h1FFC_45_45,
    32'h1FFC_BF_07, 32'h1FFD_31_31, 32'h1FFD_32_31, 32'h1FF2_81_81,
    32'h1FF0_00_5A, 32'h1FF9_30_30
  };

  function automatic string tag_of(input logic [15:0] a);
    if (a < 16'h1FF0 || a == 16'h1FF1) return "R3";
    if (a == 16'h1FF0) return "R4";
    if (a == 16'h1FF2) return "R11";
    if (a == 16'h1FF8) return "R5";
    if (a == 16'h1FFC) return "R8";
    return "R6";
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] ofs, input logic [7:0] d);
    @(negedge clk);
    bus_ofs = ofs; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] ofs, output logic [7:0] d);
    @(negedge clk);
    bus_ofs = ofs; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_addr(input logic [15:0] a);
    bus_write(2'd0, a[7:0]);
    bus_write(2'd1, a[15:8]);
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    set_addr(a);
    bus_write(2'd3, d);
  endtask

  task automatic peek(input logic [15:0] a, output logic [7:0] d);
    set_addr(a);
    bus_read(2'd3, d);
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check("R12 rdata", bus_rdata, 8'hFF);
    peek(16'h1FF9, d); check("R12 sec", d, 8'h00);
    peek(16'h1FFC, d); check("R12 day", d, 8'h01);
    peek(16'h1FFD, d); check("R12 date", d, 8'h01);
    peek(16'h1FFE, d); check("R12 month", d, 8'h01);
    peek(16'h1FF8, d); check("R12 ctrl", d, 8'h00);
    check("R12 wdog", wdog_cfg_o, 8'h00);

    // table walk
    for (int i = 0; i < 22; i++) begin
      poke(VEC[i][31:16], VEC[i][15:8]);
      peek(VEC[i][31:16], d);
      check(tag_of(VEC[i][31:16]), d, VEC[i][7:0]);
    end
    check("R11 alarm_sec_o", alarm_sec_o, 8'h81);

    // R1 high address byte selects distinct bytes; non-data offset reads 0xFF
    poke(16'h0023, 8'h11);
    poke(16'h0123, 8'h5C);
    peek(16'h0023, d); check("R1 low page", d, 8'h11);
    peek(16'h0123, d); check("R1 high page", d, 8'h5C);
    bus_read(2'd1, d); check("R1 offset1 read", d, 8'hFF);

    // R2 address clears after data write
    poke(16'h0010, 8'hA5);
    bus_write(2'd3, 8'h77);
    peek(16'h0000, d); check("R2 cleared addr", d, 8'h77);
    peek(16'h0010, d); check("R2 old addr kept", d, 8'hA5);

    // R11 remaining config bytes
    poke(16'h1FF3, 8'h47); poke(16'h1FF4, 8'hC2);
    poke(16'h1FF5, 8'h1E); poke(16'h1FF6, 8'h3B);
    check("R11 alarm_min_o", alarm_min_o, 8'h47);
    check("R11 alarm_hour_o", alarm_hour_o, 8'hC2);
    check("R11 alarm_date_o", alarm_date_o, 8'h1E);
    check("R11 irq_cfg_o", irq_cfg_o, 8'h3B);

    // R4 watchdog restart pulses
    r0 = n_restart;
    poke(16'h1FF7, 8'h35);
    @(negedge clk);
    check("R4 wdog_cfg_o", wdog_cfg_o, 8'h35);
    check("R4 restart on write", 8'(n_restart - r0), 8'd1);
    peek(16'h1FF0, d);
    @(negedge clk);
    check("R4 flags read", d, 8'h5A);
    check("R4 restart on flag read", 8'(n_restart - r0), 8'd2);

    // R9 full ripple
    poke(16'h1FFF, 8'h99); poke(16'h1FFE, 8'h12); poke(16'h1FFD, 8'h31);
    poke(16'h1FFC, 8'h07); poke(16'h1FFB, 8'h23); poke(16'h1FFA, 8'h59);
    poke(16'h1FF9, 8'h59);
    tick();
    peek(16'h1FF9, d); check("R9 sec wrap", d, 8'h00);
    peek(16'h1FFA, d); check("R9 min wrap", d, 8'h00);
    peek(16'h1FFB, d); check("R9 hour wrap", d, 8'h00);
    peek(16'h1FFC, d); check("R9 weekday+century", d, 8'h41);
    peek(16'h1FFD, d); check("R9 date wrap", d, 8'h01);
    peek(16'h1FFE, d); check("R9 month wrap", d, 8'h01);
    peek(16'h1FFF, d); check("R9 year wrap", d, 8'h00);
    poke(16'h1FF9, 8'h09);
    tick();
    peek(16'h1FF9, d); check("R9 digit carry", d, 8'h10);

    // R7 stop bit
    poke(16'h1FF9, 8'hFF);
    peek(16'h1FF9, d); check("R7 stop set", d, 8'h90);
    tick(); tick();
    peek(16'h1FF9, d); check("R7 frozen", d, 8'h90);
    poke(16'h1FF9, 8'h7F);
    peek(16'h1FF9, d); check("R7 resumed held", d, 8'h10);
    tick();
    peek(16'h1FF9, d); check("R7 counting", d, 8'h11);

    // R10 tick coinciding with a clock-page write
    poke(16'h1FF9, 8'h20);
    set_addr(16'h1FFA);
    @(negedge clk);
    bus_ofs = 2'd3; bus_wdata = 8'h11; bus_wr = 1'b1; sec_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; sec_tick = 1'b0;
    peek(16'h1FF9, d); check("R10 tick dropped", d, 8'h20);
    peek(16'h1FFA, d); check("R10 write taken", d, 8'h11);

    finish_run();
  end
endmodule